// File: doc/BRIEF.md
# Four-Tributary Byte-Interleave Transmit Multiplexer

This block combines four lower-rate SONET tributaries into one stream at four times the byte rate. Each tributary supplies an 8-bit byte, a parity bit and a frame pulse. All four tributaries present a new byte in the same cycle, marked by a common strobe that must recur every fourth clock. The block checks parity on every tributary byte. It takes the captured bytes in a fixed rotation and emits one byte per clock on an 8-bit output with a frame marker.

Inside the output frame the block can write the section-trace bytes, the section BIP-8 byte and frame-synchronous scrambling, and each of these can be switched on or off. The framing bytes at the head of row 1 pass through untouched. The frame size (rows, bytes per row) and the counts of the two framing groups and the trace group are parameters, so a reduced frame can be used in simulation. The B1 position is the first byte of row 2. The scrambler starts at the byte after the trace group.

Top module: `trib_interleave_tx`

## Requirements
- R1: While reset is high and until lock is gained, `out_data` is 0x00 and `out_fp` is low. `par_err` is 0 while reset is high.
- R2: Output starts only after a strobe cycle in which all four `trib_fp` bits are high. A strobe with only some pulses high does not start output. Once gained, lock is held until reset.
- R3: Output byte position p of the frame carries tributary (p mod 4), byte (p div 4) of that tributary's frame. Tributary 0 is sent first.
- R4: The first A1_BYTES+A2_BYTES output positions of row 1 pass the tributary bytes unchanged and are never scrambled.
- R5: With `trace_en` high, trace position t (0-based, the t-th byte after the framing group) is replaced by the value t+1 modulo 256. With `trace_en` low, those positions carry the tributary data.
- R6: With `b1_en` high, position COLS (first byte of row 2) carries the XOR of all output bytes of the previous frame, inserted before scrambling. In the first frame after lock this value is 0x00.
- R7: With `scr_en` high, every position from A1_BYTES+A2_BYTES+TRACE_BYTES to the end of the frame is XORed with the 1+x^6+x^7 sequence, MSB first. The sequence restarts from all ones at that position in every frame, so its first two key bytes are 0xFE and 0x04. With `scr_en` low, no byte is altered.
- R8: `par_err[i]` is high for exactly one clock, the cycle after a strobe, when tributary i's parity mismatches the mode set by `par_odd` (1 = odd, 0 = even). A correctly coded byte raises no error.
- R9: With `par_with_fp` high, the frame pulse bit counts in the parity sum along with the data byte.
- R10: `out_fp` is high for one clock, in the same cycle as output position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output byte-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| trib_strobe | input | 1 | High in the cycle that all tributary buses carry a new byte; every fourth clock |
| trib_data | input | 4x8 | Tributary bytes, index = tributary number |
| trib_par | input | 4 | Tributary parity bits |
| trib_fp | input | 4 | Tributary frame pulses, high on the first byte of a tributary frame |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| par_with_fp | input | 1 | 1 includes the frame pulse in the parity sum |
| b1_en | input | 1 | Enable BIP-8 insertion |
| trace_en | input | 1 | Enable trace byte overwrite |
| scr_en | input | 1 | Enable frame-synchronous scrambling |
| out_data | output | 8 | Interleaved output byte |
| out_fp | output | 1 | High with output position 0 |
| par_err | output | 4 | Per-tributary parity error pulse |

## Verification
A strobe sampled on edge t yields `par_err` after edge t, and tributary 0's byte leaves the output register on edge t+1. Tributaries 1 to 3 follow on the three edges after that. The B1 byte reflects the frame that ended before it, so each frame check takes the preceding captured frame as its reference. The bench drives inputs on falling edges and samples one falling edge later. It counts frame positions from the `out_fp` sample, so every expected byte is compared in the cycle its register makes it visible.

// File: rtl/tix_pkg.sv
package tix_pkg;

    localparam int NTRIB  = 4;
    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    localparam logic [6:0] SCR_SEED = 7'h7F;

    // one scrambler step of a whole byte: key bits MSB first, next state
    typedef struct packed {
        byte_t      key;
        logic [6:0] state;
    } scr_out_t;

    // output register contents
    typedef struct packed {
        byte_t data;
        logic  fp;
    } tx_beat_t;

    function automatic scr_out_t scr_advance(input logic [6:0] s_in);
        scr_out_t   r;
        logic [6:0] s;
        s = s_in;
        r = '0;
        for (int b = BYTE_W - 1; b >= 0; b--) begin
            r.key[b] = s[6];
            s = {s[5:0], s[6] ^ s[5]};
        end
        r.state = s;
        return r;
    endfunction

    function automatic logic parity_bad(input byte_t d, input logic p, input logic fp,
                                        input logic odd, input logic wfp);
        return (^d) ^ (wfp & fp) ^ p ^ odd;
    endfunction

endpackage

// File: rtl/tix_trib_port.sv
module tix_trib_port import tix_pkg::*; (
    input  logic  clk,
    input  logic  rst,
    input  logic  strobe,
    input  byte_t din,
    input  logic  par,
    input  logic  fp,
    input  logic  par_odd,
    input  logic  par_with_fp,
    output byte_t held,
    output logic  par_err
);

    always_ff @(posedge clk) begin
        if (rst) begin
            held    <= '0;
            par_err <= 1'b0;
        end else begin
            par_err <= strobe & parity_bad(din, par, fp, par_odd, par_with_fp);
            if (strobe) held <= din;
        end
    end

    // an error pulse only ever follows a strobe cycle
    p_err_after_strobe_r8: assert property (@(posedge clk) disable iff (rst)
        par_err |-> $past(strobe));

endmodule

// File: rtl/tix_frame_seq.sv
module tix_frame_seq import tix_pkg::*; #(
    parameter int FRAME = 38880,
    localparam int PW = $clog2(FRAME)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe,
    input  logic [NTRIB-1:0] fp_all,
    output logic             locked,
    output logic [PW-1:0]    pos
);

    localparam logic [PW-1:0] LAST_P = PW'(FRAME - 1);

    logic all_fp;
    assign all_fp = strobe & (&fp_all);

    always_ff @(posedge clk) begin
        if (rst) begin
            locked <= 1'b0;
            pos    <= '0;
        end else if (all_fp) begin
            locked <= 1'b1;
            pos    <= '0;
        end else if (locked) begin
            pos <= (pos == LAST_P) ? '0 : pos + PW'(1);
        end
    end

    p_lock_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        locked |=> locked);

    p_lock_cause_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(strobe && (&fp_all)));

endmodule

// File: rtl/tix_tx_stage.sv
module tix_tx_stage import tix_pkg::*; #(
    parameter int ROWS        = 9,
    parameter int COLS        = 4320,
    parameter int A1_BYTES    = 48,
    parameter int A2_BYTES    = 48,
    parameter int TRACE_BYTES = 48,
    localparam int FRAME = ROWS * COLS,
    localparam int PW    = $clog2(FRAME)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          locked,
    input  logic [PW-1:0] pos,
    input  byte_t         cap_byte,
    input  logic          b1_en,
    input  logic          trace_en,
    input  logic          scr_en,
    output byte_t         out_data,
    output logic          out_fp
);

    localparam logic [PW-1:0] TRB_P  = PW'(A1_BYTES + A2_BYTES);
    localparam logic [PW-1:0] SCS_P  = PW'(A1_BYTES + A2_BYTES + TRACE_BYTES);
    localparam logic [PW-1:0] B1_P   = PW'(COLS);
    localparam logic [PW-1:0] LAST_P = PW'(FRAME - 1);

    tx_beat_t   beat_q;
    logic [6:0] lfsr_q;
    byte_t      acc_q, b1_q;
    byte_t      pre, fin, acc_n;
    scr_out_t   scr;

    always_comb begin
        pre = cap_byte;
        if (trace_en && pos >= TRB_P && pos < SCS_P)
            pre = byte_t'(pos - TRB_P) + 8'd1;
        if (b1_en && pos == B1_P)
            pre = b1_q;
        scr   = scr_advance((pos == SCS_P) ? SCR_SEED : lfsr_q);
        fin   = (scr_en && pos >= SCS_P) ? (pre ^ scr.key) : pre;
        acc_n = ((pos == '0) ? '0 : acc_q) ^ fin;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
            lfsr_q <= SCR_SEED;
            acc_q  <= '0;
            b1_q   <= '0;
        end else if (locked) begin
            beat_q <= '{data: fin, fp: (pos == '0)};
            if (pos >= SCS_P) lfsr_q <= scr.state;
            acc_q <= acc_n;
            if (pos == LAST_P) b1_q <= acc_n;
        end else begin
            beat_q <= '0;
        end
    end

    assign out_data = beat_q.data;
    assign out_fp   = beat_q.fp;

    p_fp_single_r10: assert property (@(posedge clk) disable iff (rst)
        out_fp |=> !out_fp);

    p_framing_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (locked && pos < TRB_P) |=> out_data == $past(cap_byte));

    p_seed_key_r7: assert property (@(posedge clk) disable iff (rst)
        (locked && scr_en && pos == SCS_P) |=> out_data == ($past(cap_byte) ^ 8'hFE));

endmodule

// File: rtl/trib_interleave_tx.sv
module trib_interleave_tx import tix_pkg::*; #(
    parameter int ROWS        = 9,
    parameter int COLS        = 4320,
    parameter int A1_BYTES    = 48,
    parameter int A2_BYTES    = 48,
    parameter int TRACE_BYTES = 48
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           trib_strobe,
    input  logic [NTRIB-1:0][BYTE_W-1:0]   trib_data,
    input  logic [NTRIB-1:0]               trib_par,
    input  logic [NTRIB-1:0]               trib_fp,
    input  logic                           par_odd,
    input  logic                           par_with_fp,
    input  logic                           b1_en,
    input  logic                           trace_en,
    input  logic                           scr_en,
    output logic [BYTE_W-1:0]              out_data,
    output logic                           out_fp,
    output logic [NTRIB-1:0]               par_err
);

    localparam int FRAME = ROWS * COLS;
    localparam int PW    = $clog2(FRAME);
    localparam int LW    = $clog2(NTRIB);

    byte_t         held [NTRIB];
    byte_t         cap_byte;
    logic          locked;
    logic [PW-1:0] pos;

    for (genvar g = 0; g < NTRIB; g++) begin : g_lane
        tix_trib_port u_port (
            .clk         (clk),
            .rst         (rst),
            .strobe      (trib_strobe),
            .din         (trib_data[g]),
            .par         (trib_par[g]),
            .fp          (trib_fp[g]),
            .par_odd     (par_odd),
            .par_with_fp (par_with_fp),
            .held        (held[g]),
            .par_err     (par_err[g])
        );
    end

    tix_frame_seq #(.FRAME(FRAME)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .strobe (trib_strobe),
        .fp_all (trib_fp),
        .locked (locked),
        .pos    (pos)
    );

    // rotation: the low bits of the frame position pick the lane
    assign cap_byte = held[pos[LW-1:0]];

    tix_tx_stage #(
        .ROWS        (ROWS),
        .COLS        (COLS),
        .A1_BYTES    (A1_BYTES),
        .A2_BYTES    (A2_BYTES),
        .TRACE_BYTES (TRACE_BYTES)
    ) u_tx (
        .clk      (clk),
        .rst      (rst),
        .locked   (locked),
        .pos      (pos),
        .cap_byte (cap_byte),
        .b1_en    (b1_en),
        .trace_en (trace_en),
        .scr_en   (scr_en),
        .out_data (out_data),
        .out_fp   (out_fp)
    );

endmodule

// File: tb/trib_interleave_tx_test.sv
module trib_interleave_tx_test;

    localparam int ROWS = 3, COLS = 32, A1N = 4, A2N = 4, TRN = 4;
    localparam int FRAME = ROWS * COLS;
    localparam int TK    = FRAME / 4;
    localparam int TRB   = A1N + A2N;
    localparam int SCS   = TRB + TRN;
    localparam int B1P   = COLS;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic             trib_strobe = 1'b0;
    logic [3:0][7:0]  trib_data = '0;
    logic [3:0]       trib_par = '0, trib_fp = '0;
    logic             par_odd = 1'b0, par_with_fp = 1'b0;
    logic             b1_en = 1'b0, trace_en = 1'b0, scr_en = 1'b0;
    logic [7:0]       out_data;
    logic             out_fp;
    logic [3:0]       par_err;

    trib_interleave_tx #(.ROWS(ROWS), .COLS(COLS), .A1_BYTES(A1N), .A2_BYTES(A2N),
                         .TRACE_BYTES(TRN)) uut (
        .clk(clk), .rst(rst), .trib_strobe(trib_strobe), .trib_data(trib_data),
        .trib_par(trib_par), .trib_fp(trib_fp), .par_odd(par_odd),
        .par_with_fp(par_with_fp), .b1_en(b1_en), .trace_en(trace_en),
        .scr_en(scr_en), .out_data(out_data), .out_fp(out_fp), .par_err(par_err)
    );

    bit         cfg_odd = 0, cfg_wfp = 0, cfg_b1 = 0, cfg_trace = 0, cfg_scr = 0, drv_on = 0;
    logic [3:0] fp_mask = 4'hF, bad_mask = 4'h0, pend_err = 4'h0;
    int         bad_k = 0, salt = 0, tk = 0, ph = 0;
    int         err_seen = 0, err_wrong = 0, tests = 0, fails = 0;
    logic [7:0] keyb [FRAME];
    logic [7:0] got  [3][FRAME];

    function automatic logic [7:0] tbyte(input int i, input int k);
        if (k == 0) return 8'hF6;
        if (k == 1) return 8'h28;
        return 8'((i * 37 + k * 13 + salt) & 255);
    endfunction

    function automatic logic [7:0] exp_byte(input int p, input logic [7:0] prev);
        logic [7:0] v;
        v = tbyte(p % 4, p / 4);
        if (cfg_trace && p >= TRB && p < SCS) v = 8'(p - TRB + 1);
        if (cfg_b1 && p == B1P) v = prev;
        if (cfg_scr && p >= SCS) v = v ^ keyb[p - SCS];
        return v;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // tributary source and parity pulse monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (par_err !== pend_err) err_wrong++;
            err_seen += $countones(par_err);
        end
        pend_err    = '0;
        trib_strobe = 1'b0;
        trib_fp     = '0;
        par_odd     = cfg_odd;
        par_with_fp = cfg_wfp;
        b1_en       = cfg_b1;
        trace_en    = cfg_trace;
        scr_en      = cfg_scr;
        if (rst) begin
            tk = 0;
            ph = 0;
        end else if (drv_on) begin
            if (ph == 0) begin
                trib_strobe = 1'b1;
                for (int i = 0; i < 4; i++) begin
                    logic [7:0] d;
                    logic f, p;
                    d = tbyte(i, tk);
                    f = (tk == 0) && fp_mask[i];
                    p = (^d) ^ (cfg_wfp & f) ^ cfg_odd;
                    if (bad_mask[i] && tk == bad_k) begin
                        p = ~p;
                        pend_err[i] = 1'b1;
                    end
                    trib_data[i] = d;
                    trib_fp[i]   = f;
                    trib_par[i]  = p;
                end
                tk = (tk + 1) % TK;
            end
            ph = (ph + 1) % 4;
        end
    end

    task automatic grab3(input string tag);
        int guard = 0;
        int badfp = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (out_fp !== 1'b1 && guard < 4 * FRAME);
        for (int n = 0; n < 3 * FRAME; n++) begin
            if (n > 0) @(negedge clk);
            got[n / FRAME][n % FRAME] = out_data;
            if (out_fp !== (n % FRAME == 0)) badfp++;
        end
        chk(badfp == 0, {tag, " R10 out_fp marks position 0 only"}, badfp, 0);
    endtask

    task automatic check_frames(input string tag);
        for (int f = 1; f < 3; f++) begin
            logic [7:0] prev = 8'h00;
            int bad = 0, fa = 0, fe = 0;
            for (int p = 0; p < FRAME; p++) prev ^= got[f - 1][p];
            for (int p = 0; p < FRAME; p++) begin
                logic [7:0] e;
                e = exp_byte(p, prev);
                if (got[f][p] !== e) begin
                    if (bad == 0) begin fa = got[f][p]; fe = e; end
                    bad++;
                end
            end
            chk(bad == 0, tag, fa, fe);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (4) @(negedge clk);
        chk(out_data === 8'h00 && out_fp === 1'b0 && par_err === 4'h0,
            "R1 outputs idle in reset", {out_fp, par_err, out_data}, 0);
        rst = 1'b0;
    endtask

    task automatic t_no_lock();
        int seen = 0;
        fp_mask = 4'b1011;
        drv_on  = 1;
        do_reset();
        repeat (4 * FRAME) begin
            @(negedge clk);
            if (out_fp !== 1'b0 || out_data !== 8'h00) seen++;
        end
        chk(seen == 0, "R2 R1 no output with tributary 2 pulse missing", seen, 0);
        fp_mask = 4'hF;
    endtask

    task automatic t_plain();
        cfg_b1 = 0; cfg_trace = 0; cfg_scr = 0; salt = 3;
        grab3("plain");
        check_frames("R3 R4 plain interleave frame");
        chk(got[1][0] === 8'hF6 && got[1][3] === 8'hF6 && got[1][4] === 8'h28 &&
            got[1][7] === 8'h28, "R4 framing bytes", got[1][4], 8'h28);
        chk(got[1][13] === tbyte(1, 3), "R3 position 13 from tributary 1", got[1][13], tbyte(1, 3));
        chk(got[1][TRB] === tbyte(0, 2), "R5 trace off passes data", got[1][TRB], tbyte(0, 2));
    endtask

    task automatic t_trace();
        cfg_trace = 1; salt = 9;
        grab3("trace");
        check_frames("R5 trace overwrite frame");
        chk(got[2][TRB + 3] === 8'h04, "R5 last trace byte", got[2][TRB + 3], 8'h04);
        cfg_trace = 0;
    endtask

    task automatic t_b1_first();
        cfg_b1 = 1; salt = 21;
        do_reset();
        grab3("b1");
        chk(got[0][B1P] === 8'h00, "R6 first frame after lock carries zero", got[0][B1P], 0);
        check_frames("R6 B1 frame");
    endtask

    task automatic t_scr();
        cfg_scr = 1; cfg_trace = 1; cfg_b1 = 1; salt = 40;
        grab3("scr");
        check_frames("R7 scrambled frame");
        chk(got[1][SCS] === (tbyte(0, SCS / 4) ^ 8'hFE), "R7 first key byte",
            got[1][SCS], tbyte(0, SCS / 4) ^ 8'hFE);
        chk(got[1][SCS + 1] === (tbyte(1, SCS / 4) ^ 8'h04), "R7 second key byte",
            got[1][SCS + 1], tbyte(1, SCS / 4) ^ 8'h04);
        chk(got[2][0] === 8'hF6 && got[2][TRB - 1] === 8'h28, "R4 framing unscrambled",
            got[2][0], 8'hF6);
        cfg_scr = 0; cfg_trace = 0; cfg_b1 = 0;
    endtask

    task automatic t_par(input bit odd, input bit wfp, input int k, input string tag);
        int w0, s0;
        cfg_odd = odd; cfg_wfp = wfp; bad_mask = 4'h0;
        repeat (8) @(negedge clk);
        w0 = err_wrong; s0 = err_seen;
        repeat (2 * FRAME) @(negedge clk);
        chk(err_wrong == w0 && err_seen == s0, {tag, " clean stream no error"},
            err_seen - s0, 0);
        bad_mask = 4'b0110; bad_k = k;
        w0 = err_wrong; s0 = err_seen;
        repeat (2 * FRAME) @(negedge clk);
        bad_mask = 4'h0;
        repeat (8) @(negedge clk);
        chk(err_wrong == w0, {tag, " pulses on bad bytes only"}, err_wrong - w0, 0);
        chk(err_seen > s0, {tag, " pulses seen"}, err_seen - s0, 1);
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
        $finish;
    end

    initial begin
        begin
            bit bits [FRAME * 8];
            for (int n = 0; n < FRAME * 8; n++)
                bits[n] = (n < 7) ? 1'b1 : (bits[n - 6] ^ bits[n - 7]);
            for (int j = 0; j < FRAME; j++)
                for (int b = 0; b < 8; b++) keyb[j][7 - b] = bits[8 * j + b];
        end
        repeat (3) @(negedge clk);
        chk(out_data === 8'h00 && out_fp === 1'b0 && par_err === 4'h0,
            "R1 reset state", {out_fp, par_err, out_data}, 0);
        t_no_lock();
        t_plain();
        t_trace();
        t_b1_first();
        t_scr();
        t_par(0, 0, 5, "R8 even parity");
        t_par(1, 0, 7, "R8 odd parity");
        t_par(0, 1, 0, "R9 even parity with frame pulse");
        t_par(1, 1, 0, "R9 odd parity with frame pulse");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule